// File: doc/BRIEF.md
# Speculative Bit-Serial Mesh Router Node

This node sits at one position of a two-dimensional mesh whose links are a single wire wide plus a valid line. A message starts with two address flits, the column coordinate followed by the row coordinate, and the payload follows. A message is routed along the column dimension first and then along the row dimension. The node does not hold a bit back while it decodes the address. Every arriving bit leaves on the output that continues in the same dimension one clock later. The node compares the address flit with its own coordinate bit by bit, and it makes the routing decision in parallel with the transmission.

When an address flit fully matches, the guess to continue straight was wrong. The node then drops valid on the straight output for the final address bit. The downstream node therefore receives a fragment shorter than a flit, which is the dead flit it must discard. The remainder of the message is steered to the row output, or to the local ejection port when both coordinates match. Traffic that arrives on the row input already has its column flit stripped, so it carries only the row address. A low valid line marks the end of a message and frees the path it used.

Top module: `mp_serial_node`

## Requirements
- R1: Each valid bit that arrives on the column input while a column address is being received appears unchanged on the column output exactly one clock later.
- R2: When the column address flit differs from the node's column coordinate in any bit, including only its last bit, the whole message appears on the column output as one contiguous burst. This covers both address flits and the payload.
- R3: When the column address flit equals the node's column coordinate, the column output carries only the first FLIT_W-1 address bits and then goes invalid. The burst is a dead fragment shorter than one flit.
- R4: After a column match, the row address flit and the payload appear on the row output. The first of these bits appears in the clock after the last column address bit has been output.
- R5: When both coordinates match, the row output carries a dead fragment of FLIT_W-1 row address bits, and only the payload bits appear on the ejection port. Address bits never reach the ejection port.
- R6: A message on the row input is compared against the row coordinate only. On a mismatch the whole message goes to the row output one clock later. On a match the row output carries a dead fragment and the payload goes to the ejection port.
- R7: A low valid on an input ends the message in progress and frees its path, even in the middle of an address flit. The next valid bit starts a new address flit.
- R8: After reset, all three outputs are invalid.
- R9: Whenever an output's valid is low, its data line is low.
- R10: When the turned column stream and a row-input stream want the row output, or the ejection port, in the same clock, the turned column stream is sent and the other bits are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in_v | input | 1 | Column input valid |
| x_in_d | input | 1 | Column input serial data, MSB first |
| y_in_v | input | 1 | Row input valid |
| y_in_d | input | 1 | Row input serial data, MSB first |
| x_out_v | output | 1 | Column output valid |
| x_out_d | output | 1 | Column output data |
| y_out_v | output | 1 | Row output valid |
| y_out_d | output | 1 | Row output data |
| ej_v | output | 1 | Ejection port valid |
| ej_d | output | 1 | Ejection port data |

## Verification
The bench builds the node with 4-bit flits, column coordinate 5 (0101) and row coordinate 3 (0011) in an 8-by-8 mesh. With these values, addresses that differ from the coordinate only in their final bit can be sent, for example column address 4 or row address 2. That puts the speculative decision at its latest possible point and separates a near match from a dead fragment. The 4-bit width also keeps the three-bit dead fragments and the exact cycle of the turn easy to predict. Running both inputs at once brings the row-output collision within reach.

// File: rtl/mp_serial_node.sv
module mp_serial_node #(
  parameter int FLIT_W   = 4,
  parameter int MESH_DIM = 4,
  parameter int MY_X     = 1,
  parameter int MY_Y     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in_v,
  input  logic x_in_d,
  input  logic y_in_v,
  input  logic y_in_d,
  output logic x_out_v,
  output logic x_out_d,
  output logic y_out_v,
  output logic y_out_d,
  output logic ej_v,
  output logic ej_d
);

  localparam int CW = (FLIT_W > 2) ? $clog2(FLIT_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLIT_W - 1);
  localparam logic [FLIT_W-1:0] XC = FLIT_W'(MY_X);
  localparam logic [FLIT_W-1:0] YC = FLIT_W'(MY_Y);

  typedef enum logic [2:0] {HX, HY, PX, PY, PE} st_t;

  initial begin
    cfg_chk: assert (MESH_DIM <= 2**FLIT_W && MY_X < MESH_DIM && MY_Y < MESH_DIM && FLIT_W >= 2);
  end

  st_t st [2];
  st_t st_n [2];
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] cnt_n [2];
  logic eq [2];
  logic eq_n [2];
  logic iv [2];
  logic id [2];
  logic to_x [2];
  logic to_y [2];
  logic to_e [2];

  assign iv[0] = x_in_v;
  assign iv[1] = y_in_v;
  assign id[0] = x_in_d;
  assign id[1] = y_in_d;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic ref_b, hit, last, hdr, turn;
      ref_b = (st[k] == HX) ? XC[LAST - cnt[k]] : YC[LAST - cnt[k]];
      hit   = eq[k] & (id[k] == ref_b);
      last  = (cnt[k] == LAST);
      hdr   = (st[k] == HX) || (st[k] == HY);
      turn  = iv[k] & hdr & last & hit;
      to_x[k] = iv[k] & (((st[k] == HX) & ~turn) | (st[k] == PX));
      to_y[k] = iv[k] & (((st[k] == HY) & ~turn) | (st[k] == PY));
      to_e[k] = iv[k] & (st[k] == PE);
      st_n[k]  = st[k];
      cnt_n[k] = cnt[k];
      eq_n[k]  = eq[k];
      if (!iv[k]) begin
        st_n[k]  = (k == 0) ? HX : HY;
        cnt_n[k] = '0;
        eq_n[k]  = 1'b1;
      end else if (hdr) begin
        if (last) begin
          cnt_n[k] = '0;
          eq_n[k]  = 1'b1;
          if (st[k] == HX) st_n[k] = turn ? HY : PX;
          else             st_n[k] = turn ? PE : PY;
        end else begin
          cnt_n[k] = cnt[k] + 1'b1;
          eq_n[k]  = hit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st[0]  <= HX;
      st[1]  <= HY;
      cnt[0] <= '0;
      cnt[1] <= '0;
      eq[0]  <= 1'b1;
      eq[1]  <= 1'b1;
      x_out_v <= 1'b0;
      x_out_d <= 1'b0;
      y_out_v <= 1'b0;
      y_out_d <= 1'b0;
      ej_v    <= 1'b0;
      ej_d    <= 1'b0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        st[k]  <= st_n[k];
        cnt[k] <= cnt_n[k];
        eq[k]  <= eq_n[k];
      end
      x_out_v <= to_x[0];
      x_out_d <= to_x[0] & id[0];
      y_out_v <= to_y[0] | to_y[1];
      y_out_d <= to_y[0] ? id[0] : (to_y[1] & id[1]);
      ej_v    <= to_e[0] | to_e[1];
      ej_d    <= to_e[0] ? id[0] : (to_e[1] & id[1]);
    end
  end

  // R1
  x_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_out_v |-> ($past(x_in_v) && x_out_d == $past(x_in_d)));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_out_v -> !x_out_d) && (!y_out_v -> !y_out_d) && (!ej_v -> !ej_d));

  // R5
  ej_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_v |-> $past(x_in_v || y_in_v));

  // R2
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] == PX && x_in_v) |=> st[0] == PX);

  // R7
  tail_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !x_in_v |=> (st[0] == HX && cnt[0] == '0));

  // R3
  dead_frag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] == HY && $past(st[0]) == HX) |-> !x_out_v);

endmodule

// File: tb/mp_serial_node_tb.sv
module mp_serial_node_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_in_v = 1'b0, x_in_d = 1'b0, y_in_v = 1'b0, y_in_d = 1'b0;
  logic x_out_v, x_out_d, y_out_v, y_out_d, ej_v, ej_d;

  int checks = 0;
  int errors = 0;
  logic [63:0] o0, o1, oe;
  int n0, n1, ne, f0, f1, fe, zviol;

  always #10 clk = ~clk;

  mp_serial_node #(.FLIT_W(4), .MESH_DIM(8), .MY_X(5), .MY_Y(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .x_in_v(x_in_v), .x_in_d(x_in_d), .y_in_v(y_in_v), .y_in_d(y_in_d),
    .x_out_v(x_out_v), .x_out_d(x_out_d), .y_out_v(y_out_v), .y_out_d(y_out_d),
    .ej_v(ej_v), .ej_d(ej_d)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] m0, input int l0, input logic [63:0] m1, input int l1);
    int lim;
    o0 = '0; o1 = '0; oe = '0;
    n0 = 0; n1 = 0; ne = 0; f0 = -1; f1 = -1; fe = -1; zviol = 0;
    lim = ((l0 > l1) ? l0 : l1) + 3;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (x_out_v) begin if (n0 == 0) f0 = i; o0 = {o0[62:0], x_out_d}; n0++; end
      else if (x_out_d) zviol++;
      if (y_out_v) begin if (n1 == 0) f1 = i; o1 = {o1[62:0], y_out_d}; n1++; end
      else if (y_out_d) zviol++;
      if (ej_v) begin if (ne == 0) fe = i; oe = {oe[62:0], ej_d}; ne++; end
      else if (ej_d) zviol++;
      x_in_v = (i < l0);
      x_in_d = (i < l0) ? m0[l0-1-i] : 1'b0;
      y_in_v = (i < l1);
      y_in_d = (i < l1) ? m1[l1-1-i] : 1'b0;
    end
    chk("R9 data low while invalid", zviol, 0);
  endtask

  task automatic t_reset;
    chk("R8 outputs after reset", {x_out_v, y_out_v, ej_v}, 3'b000);
  endtask

  task automatic t_straight;
    run({4'h6, 4'h3, 8'hA5}, 16, '0, 0);
    chk("R1 first bit latency", f0, 1);
    chk("R2 straight stream", o0, 64'h63A5);
    chk("R2 straight length", n0, 16);
    chk("R2 nothing on row or eject", n1 + ne, 0);
  endtask

  task automatic t_late_mismatch;
    run({4'h4, 4'h3, 8'hA5}, 16, '0, 0);
    chk("R2 last-bit mismatch stream", o0, 64'h43A5);
    chk("R2 last-bit mismatch length", n0, 16);
  endtask

  task automatic t_turn;
    run({4'h5, 4'h6, 8'h3C}, 16, '0, 0);
    chk("R3 dead fragment bits", o0, 64'h2);
    chk("R3 dead fragment length", n0, 3);
    chk("R4 turned stream", o1, 64'h63C);
    chk("R4 turned length", n1, 12);
    chk("R4 turned first cycle", f1, 5);
    chk("R4 no eject", ne, 0);
  endtask

  task automatic t_eject_x;
    run({4'h5, 4'h3, 8'hC3}, 16, '0, 0);
    chk("R3 column fragment", {n0[7:0], o0[7:0]}, {8'd3, 8'h2});
    chk("R5 row fragment", {n1[7:0], o1[7:0]}, {8'd3, 8'h1});
    chk("R5 ejected payload", {ne[7:0], oe[7:0]}, {8'd8, 8'hC3});
    chk("R5 eject first cycle", fe, 9);
  endtask

  task automatic t_row_input;
    run('0, 0, {4'h2, 8'h5A}, 12);
    chk("R6 row pass stream", {n1[7:0], o1[15:0]}, {8'd12, 16'h25A});
    chk("R6 row pass first cycle", f1, 1);
    chk("R6 row pass no eject", ne + n0, 0);
    run('0, 0, {4'h3, 8'h96}, 12);
    chk("R6 row fragment", {n1[7:0], o1[7:0]}, {8'd3, 8'h1});
    chk("R6 row eject", {ne[7:0], oe[7:0]}, {8'd8, 8'h96});
    chk("R6 row eject first cycle", fe, 5);
  endtask

  task automatic t_tail;
    run(64'h1, 2, '0, 0);
    chk("R7 truncated header forwarded", {n0[7:0], o0[7:0]}, {8'd2, 8'h1});
    chk("R7 truncated header no turn", n1 + ne, 0);
    run({4'h6, 4'h3, 8'hA5}, 16, '0, 0);
    chk("R7 fresh header after tail", {n0[7:0], o0[15:0]}, {8'd16, 16'h63A5});
  endtask

  task automatic t_collide;
    run({4'h5, 4'h6, 8'h3C}, 16, {4'h2, 8'h5A}, 12);
    chk("R10 row output priority", {n1[7:0], o1[15:0]}, {8'd16, 16'h263C});
    chk("R10 column fragment", n0, 3);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_straight();
    t_late_mismatch();
    t_turn();
    t_eject_x();
    t_row_input();
    t_tail();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule